// File: doc/BRIEF.md
# Collapsing Age-Ordered Issue Queue

This block is a small scheduler that holds micro-operations waiting for execution and offers, on each of its execution ports, the oldest entry that is ready and bound to that port. Each entry carries an operation tag, the source tag it waits on, the port it was bound to when written, and a ready flag. The flag is set either when the entry is written or later, when a wakeup broadcast carries a matching source tag.

Age is the physical slot index. New entries are appended behind the live ones in program order. Whenever entries leave, the survivors slide toward slot 0 in the same cycle, so the occupied slots are always contiguous from slot 0 and a lower index always means an older entry. Selecting the oldest ready entry for a port is then a fixed-priority scan from slot 0, with no age counters and no rotating pointer.

The write side is a multi-lane valid/ready stream with one shared ready. A lane is accepted only in a cycle where its valid and the shared ready are both high. Each dispatch port is a valid/ready stream: an entry leaves only on the edge where that port's valid and ready are both high. If the ready is low, the entry stays in the queue and is offered again, although an older entry that has become ready since may take its place in the offer.

Top module: `age_issue_queue`

## Requirements
- R1: Accepted lanes are written behind all surviving entries in lane order. Lane 0 is older than lane 1, and an idle lane 0 leaves no gap. When `in_ready` is low, nothing is written.
- R2: `in_ready` is high exactly when the free slots, counted before any dispatch in that cycle, number at least INS_W (2). With 16 slots this means occupancy of 14 or less.
- R3: Entries dispatched in a cycle are removed on that same edge. The survivors are compacted toward slot 0 with no holes and keep their relative order.
- R4: For port p, `disp_valid[p]` is high exactly when some held entry has its ready flag set and its port field equal to p. `disp_op` for port p is the operation tag of the lowest-slot (oldest) such entry. Port field value 0 selects port 0 and value 1 selects port 1.
- R5: A wakeup (`wk_valid` high) sets the ready flag of every held entry whose source tag equals `wk_tag`, including entries written in that same cycle. A wakeup whose tag matches no entry changes nothing.
- R6: An entry leaves only on a clock edge where its port's `disp_valid` and `disp_ready` are both high. Otherwise it stays in the queue.
- R7: An active-low asynchronous reset empties the queue. After reset, `disp_valid` is all zero and `in_ready` is high.
- R8: Selection uses only the state held at the start of the cycle. An entry written, or woken, in a cycle is first offered in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | INS_W | Per-lane write request |
| in_ready | output | 1 | Shared write acceptance for all lanes |
| in_op | input | INS_W*OP_W | Operation tag per lane (lane 0 in the low bits) |
| in_src | input | INS_W*TAG_W | Source tag the lane's entry waits on |
| in_port | input | INS_W*PORT_W | Execution port bound to the lane's entry |
| in_rdy | input | INS_W | Entry is ready from the moment it is written |
| wk_valid | input | 1 | Wakeup broadcast valid |
| wk_tag | input | TAG_W | Tag carried by the wakeup |
| disp_valid | output | NPORT | Port has a ready entry on offer |
| disp_ready | input | NPORT | Port accepts the offered entry |
| disp_op | output | NPORT*OP_W | Operation tag offered per port (port 0 in the low bits) |

## Verification
The assertions expect every `in_port` value to name an existing port. With the defaults this always holds, because the field is one bit wide for two ports. The density, occupancy-balance and wakeup properties do not depend on the stimulus: they hold for any mix of valid, ready and wakeup, including writes attempted while the queue is full. The bench keeps port fields within range. It raises write valids freely, even when `in_ready` is low, so that dropped writes are exercised within the assumed input space.

// File: rtl/aiq_pkg.sv
package aiq_pkg;
  parameter int unsigned OP_W   = 8;
  parameter int unsigned TAG_W  = 6;
  parameter int unsigned PORT_W = 1;

  typedef struct packed {
    logic              valid;
    logic              ready;
    logic [PORT_W-1:0] port;
    logic [TAG_W-1:0]  src;
    logic [OP_W-1:0]   op;
  } slot_t;
endpackage

// File: rtl/aiq_port_pick.sv
module aiq_port_pick #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned PORT_ID = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  aiq_pkg::slot_t [DEPTH-1:0]        slots,
  output logic [DEPTH-1:0]                  grant,
  output logic                              found,
  output logic [aiq_pkg::OP_W-1:0]          op
);
  localparam logic [aiq_pkg::PORT_W-1:0] MY_PORT = aiq_pkg::PORT_W'(PORT_ID);

  // fixed-priority scan from slot 0: lowest slot is the oldest
  always_comb begin
    grant = '0;
    found = 1'b0;
    op    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && slots[i].valid && slots[i].ready && slots[i].port == MY_PORT) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        op       = slots[i].op;
      end
    end
  end

  // at most one slot may be granted per port per cycle
  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/aiq_collapse.sv
module aiq_collapse #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned INS_W = 2
) (
  input  aiq_pkg::slot_t [DEPTH-1:0]   cur,
  input  logic [DEPTH-1:0]             remove,
  input  aiq_pkg::slot_t [INS_W-1:0]   ins,
  input  logic                         wk_valid,
  input  logic [aiq_pkg::TAG_W-1:0]    wk_tag,
  output aiq_pkg::slot_t [DEPTH-1:0]   nxt
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  always_comb begin
    int unsigned pos;
    nxt = '0;
    pos = 0;
    // survivors slide toward slot 0, order preserved
    for (int i = 0; i < DEPTH; i++) begin
      if (cur[i].valid && !remove[i]) begin
        nxt[IDX_W'(pos)] = cur[i];
        pos = pos + 1;
      end
    end
    // new lanes appended behind survivors, lane 0 first
    for (int l = 0; l < INS_W; l++) begin
      if (ins[l].valid && pos < DEPTH) begin
        nxt[IDX_W'(pos)] = ins[l];
        pos = pos + 1;
      end
    end
    // wakeup reaches both old and freshly written entries
    for (int j = 0; j < DEPTH; j++) begin
      if (wk_valid && nxt[j].valid && nxt[j].src == wk_tag) begin
        nxt[j].ready = 1'b1;
      end
    end
  end
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned INS_W = 2,
  parameter int unsigned NPORT = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [INS_W-1:0]                     in_valid,
  output logic                                 in_ready,
  input  logic [INS_W*aiq_pkg::OP_W-1:0]       in_op,
  input  logic [INS_W*aiq_pkg::TAG_W-1:0]      in_src,
  input  logic [INS_W*aiq_pkg::PORT_W-1:0]     in_port,
  input  logic [INS_W-1:0]                     in_rdy,
  input  logic                                 wk_valid,
  input  logic [aiq_pkg::TAG_W-1:0]            wk_tag,
  output logic [NPORT-1:0]                     disp_valid,
  input  logic [NPORT-1:0]                     disp_ready,
  output logic [NPORT*aiq_pkg::OP_W-1:0]       disp_op
);
  import aiq_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned SUM_W = CNT_W + 2;

  slot_t [DEPTH-1:0] q_r;
  slot_t [DEPTH-1:0] q_nxt;
  slot_t [INS_W-1:0] ins_ent;
  logic  [DEPTH-1:0] occ_vec;
  logic  [CNT_W-1:0] occ;
  logic  [INS_W-1:0] ins_fire;
  logic  [DEPTH-1:0] grant   [NPORT];
  logic  [DEPTH-1:0] remove;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) occ_vec[i] = q_r[i].valid;
  end
  assign occ      = CNT_W'($countones(occ_vec));
  assign in_ready = (occ <= CNT_W'(DEPTH - INS_W));
  assign ins_fire = in_valid & {INS_W{in_ready}};

  for (genvar l = 0; l < INS_W; l++) begin : g_lane
    assign ins_ent[l].valid = ins_fire[l];
    assign ins_ent[l].ready = in_rdy[l];
    assign ins_ent[l].port  = in_port[l*PORT_W +: PORT_W];
    assign ins_ent[l].src   = in_src[l*TAG_W +: TAG_W];
    assign ins_ent[l].op    = in_op[l*OP_W +: OP_W];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    aiq_port_pick #(.DEPTH(DEPTH), .PORT_ID(p)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .slots (q_r),
      .grant (grant[p]),
      .found (disp_valid[p]),
      .op    (disp_op[p*OP_W +: OP_W])
    );
  end

  always_comb begin
    remove = '0;
    for (int p = 0; p < NPORT; p++) begin
      remove = remove | (grant[p] & {DEPTH{disp_ready[p]}});
    end
  end

  aiq_collapse #(.DEPTH(DEPTH), .INS_W(INS_W)) u_collapse (
    .cur      (q_r),
    .remove   (remove),
    .ins      (ins_ent),
    .wk_valid (wk_valid),
    .wk_tag   (wk_tag),
    .nxt      (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  // ---------------- assertions ----------------
  for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_dense
    assert_no_hole_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q_r[i+1].valid |-> q_r[i].valid);
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_wake
    assert_wake_applied_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wk_valid |=> !(q_r[j].valid && !q_r[j].ready && q_r[j].src == $past(wk_tag)));
  end

  // occupancy moves by exactly accepted writes minus handshaked dispatches
  assert_occ_balance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (SUM_W'(occ) + SUM_W'($past($countones(remove))) ==
                      SUM_W'($past(occ)) + SUM_W'($past($countones(ins_fire)))));
endmodule

// File: tb/age_issue_queue_tb.sv
`timescale 1ns/1ps
module age_issue_queue_tb;
  localparam int unsigned OP_W = 8, TAG_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_valid = '0;
  logic        in_ready;
  logic [15:0] in_op = '0;
  logic [11:0] in_src = '0;
  logic [1:0]  in_port = '0;
  logic [1:0]  in_rdy = '0;
  logic        wk_valid = 1'b0;
  logic [5:0]  wk_tag = '0;
  logic [1:0]  disp_valid;
  logic [1:0]  disp_ready = '0;
  logic [15:0] disp_op;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  age_issue_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_port(in_port), .in_rdy(in_rdy),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_op(disp_op)
  );

  typedef struct packed {
    logic [1:0] iv;
    logic [7:0] op0; logic [5:0] src0; logic p0; logic r0;
    logic [7:0] op1; logic [5:0] src1; logic p1; logic r1;
    logic       wv;  logic [5:0] wt;
    logic [1:0] dr;
    logic [1:0] edv;
    logic [7:0] eop0; logic [7:0] eop1;
  } vec_t;

  // expected outputs reflect the state left by the earlier vectors
  localparam vec_t VECS [7] = '{
    '{2'b11, 8'h10,6'd1,1'b0,1'b0, 8'h11,6'd2,1'b0,1'b1, 1'b0,6'd0, 2'b11, 2'b00, 8'h00,8'h00},
    '{2'b11, 8'h20,6'd3,1'b1,1'b1, 8'h21,6'd1,1'b1,1'b0, 1'b1,6'd1, 2'b00, 2'b01, 8'h11,8'h00},
    '{2'b00, 8'h00,6'd0,1'b0,1'b0, 8'h00,6'd0,1'b0,1'b0, 1'b0,6'd0, 2'b11, 2'b11, 8'h10,8'h20},
    '{2'b10, 8'h00,6'd0,1'b0,1'b0, 8'h30,6'd5,1'b0,1'b0, 1'b0,6'd0, 2'b01, 2'b11, 8'h11,8'h21},
    '{2'b00, 8'h00,6'd0,1'b0,1'b0, 8'h00,6'd0,1'b0,1'b0, 1'b1,6'd5, 2'b10, 2'b10, 8'h00,8'h21},
    '{2'b01, 8'h40,6'd7,1'b1,1'b0, 8'h00,6'd0,1'b0,1'b0, 1'b1,6'd9, 2'b11, 2'b01, 8'h30,8'h00},
    '{2'b00, 8'h00,6'd0,1'b0,1'b0, 8'h00,6'd0,1'b0,1'b0, 1'b0,6'd0, 2'b11, 2'b00, 8'h00,8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = '0; in_op = '0; in_src = '0; in_port = '0; in_rdy = '0;
    wk_valid = 1'b0; wk_tag = '0; disp_ready = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    do_reset();
    // R7 reset state
    chk(disp_valid == 2'b00, "R7 disp_valid after reset", 32'(disp_valid), 0);
    chk(in_ready == 1'b1, "R7 in_ready after reset", 32'(in_ready), 1);

    // vector table: R1 R3 R4 R5 R6 R8
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      in_valid   = VECS[k].iv;
      in_op      = {VECS[k].op1, VECS[k].op0};
      in_src     = {VECS[k].src1, VECS[k].src0};
      in_port    = {VECS[k].p1, VECS[k].p0};
      in_rdy     = {VECS[k].r1, VECS[k].r0};
      wk_valid   = VECS[k].wv;
      wk_tag     = VECS[k].wt;
      disp_ready = VECS[k].dr;
      #1;
      chk(disp_valid == VECS[k].edv, $sformatf("R4 R5 R8 vector %0d disp_valid", k),
          32'(disp_valid), 32'(VECS[k].edv));
      if (VECS[k].edv[0])
        chk(disp_op[7:0] == VECS[k].eop0, $sformatf("R1 R3 R4 R6 vector %0d port0 op", k),
            32'(disp_op[7:0]), 32'(VECS[k].eop0));
      if (VECS[k].edv[1])
        chk(disp_op[15:8] == VECS[k].eop1, $sformatf("R1 R3 R4 R6 vector %0d port1 op", k),
            32'(disp_op[15:8]), 32'(VECS[k].eop1));
    end

    // fill to full: R2 threshold
    do_reset();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      idle_inputs();
      #1;
      chk(in_ready == 1'b1, $sformatf("R2 in_ready at occupancy %0d", 2*c), 32'(in_ready), 1);
      in_valid = 2'b11;
      in_op    = {8'(2*c+1), 8'(2*c)};
      in_src   = {6'd3, 6'd3};
      in_port  = 2'b10;
      in_rdy   = 2'b00;
    end
    @(negedge clk);
    idle_inputs();
    #1;
    chk(in_ready == 1'b0, "R2 in_ready low when full", 32'(in_ready), 0);
    chk(disp_valid == 2'b00, "R4 no ready entry while waiting", 32'(disp_valid), 0);
    // writes while full must be dropped (R2)
    in_valid = 2'b11; in_op = {8'hEE, 8'hEE}; in_rdy = 2'b11; in_port = 2'b00;
    @(negedge clk);
    idle_inputs();
    wk_valid = 1'b1; wk_tag = 6'd3;
    @(negedge clk);
    idle_inputs();
    // drain: port0 sees even tags, port1 odd, oldest first (R4 R3)
    for (int d = 0; d < 8; d++) begin
      disp_ready = 2'b11;
      #1;
      chk(disp_valid == 2'b11, $sformatf("R5 woken entries offered step %0d", d), 32'(disp_valid), 3);
      chk(disp_op[7:0] == 8'(2*d), $sformatf("R4 R3 port0 order step %0d", d), 32'(disp_op[7:0]), 32'(2*d));
      chk(disp_op[15:8] == 8'(2*d+1), $sformatf("R4 R3 port1 order step %0d", d), 32'(disp_op[15:8]), 32'(2*d+1));
      @(negedge clk);
    end
    idle_inputs();
    #1;
    chk(disp_valid == 2'b00, "R2 dropped writes left nothing", 32'(disp_valid), 0);
    chk(in_ready == 1'b1, "R2 in_ready after drain", 32'(in_ready), 1);

    // reset with content present: R7
    @(negedge clk);
    in_valid = 2'b01; in_op = 16'h0055; in_rdy = 2'b01; in_port = 2'b00;
    @(negedge clk);
    idle_inputs();
    #1;
    chk(disp_valid == 2'b01, "R8 entry offered next cycle", 32'(disp_valid), 1);
    do_reset();
    chk(disp_valid == 2'b00, "R7 reset clears held entry", 32'(disp_valid), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule